// File: doc/BRIEF.md
# Line Control Latch and Valid-Data Flag

This block is the control and status front end of a two-wire burst transceiver. It runs on a free-running fast clock. That clock has no fixed phase relation to the 8 kHz frame reference. The block brings the frame reference, the active-low signal enable, the active-low loopback request and the power request into its own clock domain. It freezes the loopback and power requests while the enable is low. From the effective values it derives the loopback path select, the line-driver idle control and the output-enable for the data pins.

The block also keeps the valid-data flag. The demodulator reports each finished burst with a one-cycle strobe and a flag that says whether the burst was good, meaning it was synchronised and had no detected bit errors. The flag follows one of two timing disciplines. In powered mode it moves only on frame edges. In powered-down mode it follows each burst as it ends, and it decays to low after a fixed number of frame edges with no new burst. The modulator, the demodulator and the analog line are outside the block and appear only as strobes.

Top module: `lnctl_top`

## Requirements
- R1: Each control input passes through a 2-flop synchroniser. While the synchronised enable is high, `loop_eff_n` and `pwr_eff` follow the synchronised `loop_req_n` and `pwr_req`. While it is low, they hold the values they had on the last cycle before the enable fell, whatever the requests do.
- R2: `data_oe` equals the synchronised `sig_en_n`. It goes low two clock edges after the enable is driven low, which places the valid-data and D-channel pins in high impedance.
- R3: `loop_path_sel` is high exactly when `pwr_eff` is 1 and `loop_eff_n` is 0. In every other case the line input path is used.
- R4: `line_idle` is high when `tx_active` is 0, when `loop_path_sel` is 1, or when `pwr_eff` is 0. It is low only while a burst is being driven onto the line in normal powered operation.
- R5: A frame event is the synchronised `frame_ref` being high one cycle after it was low. `valid_flag` is updated on the edge after the event, so an input rise sampled at edge k takes effect at edge k+2. While `pwr_eff` is 1, `valid_flag` changes only on frame events. It takes the good bit of the last burst that ended since the previous event, or 0 if no burst ended in that interval. A burst that ends in the event cycle belongs to the frame that is closing.
- R6: While `pwr_eff` is 0, every `burst_done` strobe loads `burst_good` into `valid_flag` on the next edge, with no wait for a frame event.
- R7: While `pwr_eff` is 0 and `valid_flag` is 1, the flag clears on the third frame event that comes with no intervening burst. A burst strobe restarts that count. If a strobe and an event fall in the same cycle, the strobe wins.
- R8: During and after synchronous reset, `valid_flag` is 0, `data_oe` is 1, `loop_eff_n` is 1, `pwr_eff` is 1 and the decay count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running fast clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_ref | input | 1 | 8 kHz frame reference, asynchronous |
| sig_en_n | input | 1 | Signal enable, low freezes controls and tristates data pins |
| loop_req_n | input | 1 | Loopback request, active low |
| pwr_req | input | 1 | Power request, 1 = powered, 0 = powered down |
| burst_done | input | 1 | One-cycle strobe at end of a demodulated burst |
| burst_good | input | 1 | Burst was synchronised and error-free, valid with `burst_done` |
| tx_active | input | 1 | Modulator is driving a burst |
| loop_eff_n | output | 1 | Effective loopback request, active low |
| pwr_eff | output | 1 | Effective power mode |
| loop_path_sel | output | 1 | Route modulator output to demodulator input |
| line_idle | output | 1 | Hold both line drivers at the same high level |
| valid_flag | output | 1 | Valid-data flag |
| data_oe | output | 1 | Output-enable for valid-data and D-channel pins |

## Verification
Random traffic is split into phases. Some phases keep the power request steady at each level, so that frame-edge timing (R5) and end-of-burst timing (R6) are each exercised on their own. Other phases toggle the enable and the requests, which shows whether a frozen value truly ignores the request lines (R1). Directed sequences cover the case of several frame edges with no burst, the case of a burst after two edges that restarts the decay, and the case of a burst strobe and a frame event in the same cycle. These separate a count of three from one that is off by one, and show which input has priority. Frames with no burst in powered mode confirm that the flag drops to 0 and does not keep a stale good result.

// File: rtl/lnctl_pkg.sv
package lnctl_pkg;

    // bundle of asynchronous control lines brought into the fast domain
    typedef struct packed {
        logic msi;
        logic en;
        logic lpn;
        logic pwr;
    } lines_t;

    localparam int LINES_W = $bits(lines_t);

    // transparent, powered, enabled, frame low
    localparam lines_t LINES_RST = '{msi: 1'b0, en: 1'b1, lpn: 1'b1, pwr: 1'b1};

    typedef struct packed {
        logic lpn;
        logic pwr;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{lpn: 1'b1, pwr: 1'b1};

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/lnctl_sync.sv
module lnctl_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lnctl_latch.sv
module lnctl_latch
    import lnctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_s,
    input  ctrl_t live,
    output ctrl_t eff
);
    ctrl_t held;

    always_ff @(posedge clk) begin
        if (rst)       held <= CTRL_RST;
        else if (en_s) held <= live;
    end

    assign eff = en_s ? live : held;

    AST_FROZEN_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!en_s && !$past(en_s)) |-> $stable(eff)); // R1
endmodule

// File: rtl/lnctl_vflag.sv
module lnctl_vflag #(
    parameter int DECAY_EDGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr,
    input  logic frame_evt,
    input  logic burst_done,
    input  logic burst_good,
    output logic valid
);
    localparam int CNT_W = $clog2(DECAY_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECAY_EDGES - 1);

    logic             frame_res;
    logic [CNT_W-1:0] cnt;

    // result of the latest burst inside the current frame
    always_ff @(posedge clk) begin
        if (rst)             frame_res <= 1'b0;
        else if (frame_evt)  frame_res <= 1'b0;
        else if (burst_done) frame_res <= burst_good;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            cnt   <= '0;
        end else if (pwr) begin
            cnt <= '0;
            if (frame_evt) valid <= burst_done ? burst_good : frame_res;
        end else if (burst_done) begin
            valid <= burst_good;
            cnt   <= '0;
        end else if (frame_evt && valid) begin
            if (cnt == CNT_LAST) begin
                valid <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_PWR_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        (pwr && !frame_evt) |=> $stable(valid)); // R5
    AST_DOWN_RISE_NEEDS_BURST: assert property (@(posedge clk) disable iff (rst)
        (!pwr && !burst_done) |=> !$rose(valid)); // R6
    AST_DECAY_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST); // R7
    AST_DOWN_BURST_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!pwr && burst_done) |=> (valid == $past(burst_good))); // R6
endmodule

// File: rtl/lnctl_top.sv
module lnctl_top
    import lnctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DECAY_EDGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_ref,
    input  logic sig_en_n,
    input  logic loop_req_n,
    input  logic pwr_req,
    input  logic burst_done,
    input  logic burst_good,
    input  logic tx_active,
    output logic loop_eff_n,
    output logic pwr_eff,
    output logic loop_path_sel,
    output logic line_idle,
    output logic valid_flag,
    output logic data_oe
);
    lines_t raw, syn;
    logic   msi_prev;
    logic   frame_evt;
    ctrl_t  live, eff;

    assign raw = '{msi: frame_ref, en: sig_en_n, lpn: loop_req_n, pwr: pwr_req};

    lnctl_sync #(
        .WIDTH   (LINES_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINES_RST)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw),
        .q_sync  (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) msi_prev <= 1'b0;
        else     msi_prev <= syn.msi;
    end

    assign frame_evt = rise_of(syn.msi, msi_prev);

    assign live = '{lpn: syn.lpn, pwr: syn.pwr};

    lnctl_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .en_s (syn.en),
        .live (live),
        .eff  (eff)
    );

    lnctl_vflag #(
        .DECAY_EDGES (DECAY_EDGES)
    ) u_vflag (
        .clk        (clk),
        .rst        (rst),
        .pwr        (eff.pwr),
        .frame_evt  (frame_evt),
        .burst_done (burst_done),
        .burst_good (burst_good),
        .valid      (valid_flag)
    );

    assign loop_eff_n    = eff.lpn;
    assign pwr_eff       = eff.pwr;
    assign loop_path_sel = eff.pwr & ~eff.lpn;
    assign line_idle     = ~tx_active | loop_path_sel | ~eff.pwr;
    assign data_oe       = syn.en;

    AST_LOOP_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
        loop_path_sel |-> line_idle); // R4
    AST_LOOP_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        loop_path_sel |-> (pwr_eff && !loop_eff_n)); // R3
    AST_OE_LAGS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(sig_en_n, 2) && !$past(rst, 2) && !$past(rst)) |-> !data_oe); // R2
endmodule

// File: tb/tb_lnctl_top.sv
module tb_lnctl_top;
    logic clk = 1'b0;
    logic rst;
    logic frame_ref, sig_en_n, loop_req_n, pwr_req;
    logic burst_done, burst_good, tx_active;
    logic loop_eff_n, pwr_eff, loop_path_sel, line_idle, valid_flag, data_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lnctl_top dut (
        .clk(clk), .rst(rst), .frame_ref(frame_ref), .sig_en_n(sig_en_n),
        .loop_req_n(loop_req_n), .pwr_req(pwr_req), .burst_done(burst_done),
        .burst_good(burst_good), .tx_active(tx_active), .loop_eff_n(loop_eff_n),
        .pwr_eff(pwr_eff), .loop_path_sel(loop_path_sel), .line_idle(line_idle),
        .valid_flag(valid_flag), .data_oe(data_oe)
    );

    // requirement model state
    logic m_msi1, m_msi2, m_msip, m_en1, m_en2, m_lp1, m_lp2, m_pw1, m_pw2;
    logic m_hlp, m_hpw, m_vd, m_fr;
    int   m_cnt;

    function automatic logic eff_lp();
        return m_en2 ? m_lp2 : m_hlp;
    endfunction
    function automatic logic eff_pw();
        return m_en2 ? m_pw2 : m_hpw;
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_msi1 = 0; m_msi2 = 0; m_msip = 0;
        m_en1 = 1; m_en2 = 1; m_lp1 = 1; m_lp2 = 1; m_pw1 = 1; m_pw2 = 1;
        m_hlp = 1; m_hpw = 1; m_vd = 0; m_fr = 0; m_cnt = 0;
    endtask

    task automatic model_edge();
        logic rise, pw;
        rise = m_msi2 & ~m_msip;
        pw = eff_pw();
        if (pw) begin
            if (rise) m_vd = burst_done ? burst_good : m_fr;
            m_cnt = 0;
        end else if (burst_done) begin
            m_vd = burst_good; m_cnt = 0;
        end else if (rise && m_vd) begin
            if (m_cnt == 2) begin m_vd = 0; m_cnt = 0; end
            else m_cnt++;
        end
        if (rise) m_fr = 0; else if (burst_done) m_fr = burst_good;
        if (m_en2) begin m_hlp = m_lp2; m_hpw = m_pw2; end
        m_msip = m_msi2; m_msi2 = m_msi1; m_msi1 = frame_ref;
        m_en2 = m_en1; m_en1 = sig_en_n;
        m_lp2 = m_lp1; m_lp1 = loop_req_n;
        m_pw2 = m_pw1; m_pw1 = pwr_req;
    endtask

    task automatic compare_all();
        chk(data_oe, m_en2, "R2 data_oe");
        chk(loop_eff_n, eff_lp(), "R1 loop_eff_n");
        chk(pwr_eff, eff_pw(), "R1 pwr_eff");
        chk(loop_path_sel, eff_pw() & ~eff_lp(), "R3 loop_path_sel");
        chk(line_idle, ~tx_active | (eff_pw() & ~eff_lp()) | ~eff_pw(), "R4 line_idle");
        chk(valid_flag, m_vd, "R5 R6 R7 valid_flag");
    endtask

    // one clock: inputs already driven after the falling edge
    task automatic step();
        @(posedge clk);
        if (rst) model_reset(); else model_edge();
        #1;
        compare_all();
        @(negedge clk);
        burst_done = 0;
    endtask

    task automatic frame_pulse(input int hi, input int lo);
        frame_ref = 1;
        repeat (hi) step();
        frame_ref = 0;
        repeat (lo) step();
    endtask

    task automatic burst(input logic good);
        burst_done = 1; burst_good = good;
        step();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; frame_ref = 0; sig_en_n = 1; loop_req_n = 1; pwr_req = 1;
        burst_done = 0; burst_good = 0; tx_active = 0;
        @(negedge clk);
        repeat (3) step();
        // R8: reset state
        chk(valid_flag, 1'b0, "R8 valid_flag");
        chk(data_oe, 1'b1, "R8 data_oe");
        chk(loop_eff_n, 1'b1, "R8 loop_eff_n");
        chk(pwr_eff, 1'b1, "R8 pwr_eff");
        rst = 0;
        repeat (3) step();

        // R5: powered, good burst then frame edge, then an empty frame
        burst(1'b1);
        repeat (2) step();
        chk(valid_flag, 1'b0, "R5 no change before frame");
        frame_pulse(4, 2);
        chk(valid_flag, 1'b1, "R5 set at frame");
        frame_pulse(4, 4);
        chk(valid_flag, 1'b0, "R5 empty frame clears");

        // R6 R7: powered down, decay after three edges, restart by burst
        pwr_req = 0;
        repeat (4) step();
        burst(1'b1);
        chk(valid_flag, 1'b1, "R6 load at burst end");
        frame_pulse(3, 3);
        frame_pulse(3, 3);
        chk(valid_flag, 1'b1, "R7 still high after two edges");
        burst(1'b1);
        frame_pulse(3, 3);
        frame_pulse(3, 3);
        chk(valid_flag, 1'b1, "R7 restart kept flag");
        frame_pulse(3, 3);
        chk(valid_flag, 1'b0, "R7 cleared on third edge");
        burst(1'b0);
        chk(valid_flag, 1'b0, "R6 bad burst keeps low");

        // R1: freeze while enable low, then loopback requests ignored
        pwr_req = 1; loop_req_n = 0;
        repeat (4) step();
        chk(loop_path_sel, 1'b1, "R3 loopback active");
        sig_en_n = 0;
        repeat (3) step();
        chk(data_oe, 1'b0, "R2 tristate");
        loop_req_n = 1; pwr_req = 0;
        repeat (5) step();
        chk(loop_eff_n, 1'b0, "R1 frozen loop");
        chk(pwr_eff, 1'b1, "R1 frozen pwr");
        sig_en_n = 1;
        repeat (3) step();
        chk(pwr_eff, 1'b0, "R1 transparent again");

        // random phases
        for (int ph = 0; ph < 24; ph++) begin
            int mode = ph % 3;
            for (int c = 0; c < 400; c++) begin
                if (mode != 2) pwr_req = (mode == 0);
                else if ($urandom_range(0, 40) == 0) pwr_req = ~pwr_req;
                if (mode == 2 && $urandom_range(0, 30) == 0) sig_en_n = ~sig_en_n;
                if (mode != 2) sig_en_n = 1;
                if ($urandom_range(0, 50) == 0) loop_req_n = ~loop_req_n;
                if ((c % 20) < 4) frame_ref = 1; else frame_ref = 0;
                tx_active = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 25) == 0) begin
                    burst_done = 1; burst_good = $urandom_range(0, 1);
                end
                step();
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule